// File: doc/BRIEF.md
# Recurrence-Based 64-bit Random Value Sequencer

This block generates 64-bit pseudo-random values with a three-step recurrence built on a block cipher that it does not contain. It drives a start/done cipher engine that runs triple-DES encryption under one fixed key. The block supplies each cipher input, catches each result and keeps its working state in three 64-bit registers: S, R and V.

A request starts one generation. The first cipher call encrypts the timestamp, and the result goes to S. The second call encrypts S XOR V, and the result goes to R, which becomes the random output. The third call encrypts S XOR R, and the result replaces the seed V. The valid pulse comes only after V has been rewritten, so a new request always starts from the fresh seed. Software or a key-management unit can load a seed between generations. A seed load that arrives while a generation is running is dropped.

With a 48-cycle triple-DES engine, one output costs 144 cipher cycles plus a few control cycles. The S, R and V registers are written only on the cycles where a cipher call completes.

Top module: `rng_recur_ctrl`

## Requirements
- R1: After reset, `rnd_valid` and `cph_start` are low, `rnd_out` is zero, and the seed V is zero.
- R2: A `req` accepted while idle produces one `cph_start` pulse with `cph_din` equal to the `tstamp` value sampled at acceptance. The cipher result of this call is stored as S.
- R3: When the first call completes, the next `cph_start` carries `cph_din` = S XOR V.
- R4: When the second call completes, its result is stored as R, and the next `cph_start` carries `cph_din` = S XOR R.
- R5: When the third call completes, `rnd_valid` is high for exactly one cycle on the next cycle, with `rnd_out` equal to R.
- R6: The third call's result becomes the new V, and the following generation uses it in its second call.
- R7: A `seed_wr` pulse while idle loads `seed_in` into V.
- R8: A `seed_wr` pulse during a generation has no effect on V.
- R9: `cph_start` is a single-cycle pulse, and `cph_din` changes only together with `cph_start`. At most one cipher call is outstanding.
- R10: `rnd_out` holds its value between generations. The registers change only on a cipher completion or on a seed load.
- R11: A `req` that arrives during a generation is ignored. Each generation issues exactly three cipher calls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seed_wr | input | 1 | Seed load strobe; accepted only while idle |
| seed_in | input | 64 | Seed value to load |
| tstamp | input | 64 | Timestamp, sampled when a request is accepted |
| req | input | 1 | Request one random value |
| rnd_valid | output | 1 | One-cycle pulse: `rnd_out` holds a new value |
| rnd_out | output | 64 | Latest random value (register R) |
| cph_start | output | 1 | Start pulse to the cipher engine |
| cph_din | output | 64 | Cipher input block |
| cph_done | input | 1 | Cipher completion pulse |
| cph_dout | input | 64 | Cipher result, valid with `cph_done` |

## Verification
The assertions check the handshake shape on every cycle. They cover the single-cycle start and valid pulses, the rule that the cipher input moves only with a start, the rule that the valid pulse follows a completion, and the rule that V and S stay still outside their load cycles. Only the bench scenarios can show that the chained inputs carry the right values. They run the recurrence against a model that uses the same stub cipher under varied engine latency. They also show that a fresh seed is carried into the next generation, and that seed loads and requests made mid-generation leave the output sequence untouched.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
  // Generation phase: which cipher call is outstanding.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_S    = 2'd1,
    PH_R    = 2'd2,
    PH_V    = 2'd3
  } phase_e;

  localparam int unsigned NREG = 3;  // S, R, V
  localparam int unsigned IX_S = 0;
  localparam int unsigned IX_R = 1;
  localparam int unsigned IX_V = 2;
endpackage

// File: rtl/rngc_seq.sv
module rngc_seq
  import rngc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   cph_done,
  output phase_e phase,
  output logic   fire,
  output logic   ld_s,
  output logic   ld_r,
  output logic   ld_v,
  output logic   rnd_valid
);
  phase_e ph_q, ph_d;
  logic   vld_q, vld_d;

  always_comb begin
    ph_d  = ph_q;
    fire  = 1'b0;
    ld_s  = 1'b0;
    ld_r  = 1'b0;
    ld_v  = 1'b0;
    vld_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (req) begin
        fire = 1'b1;
        ph_d = PH_S;
      end
      PH_S: if (cph_done) begin
        ld_s = 1'b1;
        fire = 1'b1;
        ph_d = PH_R;
      end
      PH_R: if (cph_done) begin
        ld_r = 1'b1;
        fire = 1'b1;
        ph_d = PH_V;
      end
      PH_V: if (cph_done) begin
        ld_v  = 1'b1;
        vld_d = 1'b1;
        ph_d  = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      vld_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      vld_q <= vld_d;
    end
  end

  assign phase     = ph_q;
  assign rnd_valid = vld_q;

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R11
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && !cph_done) |=> (ph_q == $past(ph_q)));
endmodule

// File: rtl/rngc_regs.sv
module rngc_regs
  import rngc_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          ld_s,
  input  logic          ld_r,
  input  logic          ld_v,
  input  logic          seed_wr,
  input  logic [DW-1:0] seed_in,
  input  logic [DW-1:0] cph_dout,
  output logic [DW-1:0] s_q,
  output logic [DW-1:0] r_q,
  output logic [DW-1:0] v_q
);
  logic [NREG-1:0] en;
  logic [DW-1:0]   d [NREG];
  logic [DW-1:0]   q [NREG];
  logic            seed_ok;

  // Seed writes are honoured only between generations.
  assign seed_ok    = seed_wr && (phase == PH_IDLE);

  always_comb begin
    en[IX_S] = ld_s;
    en[IX_R] = ld_r;
    en[IX_V] = ld_v | seed_ok;
    d[IX_S]  = cph_dout;
    d[IX_R]  = cph_dout;
    d[IX_V]  = ld_v ? cph_dout : seed_in;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= '0;
      else if (en[i]) q[i] <= d[i];
    end
  end

  assign s_q = q[IX_S];
  assign r_q = q[IX_R];
  assign v_q = q[IX_V];

  // R8
  seed_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !ld_v) |=> $stable(q[IX_V]));

  // R10
  s_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s |=> $stable(q[IX_S]));
endmodule

// File: rtl/rngc_port.sv
module rngc_port
  import rngc_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          fire,
  input  logic [DW-1:0] tstamp,
  input  logic [DW-1:0] cph_dout,
  input  logic [DW-1:0] s_q,
  input  logic [DW-1:0] v_q,
  output logic          cph_start,
  output logic [DW-1:0] cph_din
);
  logic          start_q;
  logic [DW-1:0] din_q, din_d;

  // Operand for the call being launched, chosen by the call that just ended.
  always_comb begin
    unique case (phase)
      PH_IDLE: din_d = tstamp;
      PH_S:    din_d = cph_dout ^ v_q;
      PH_R:    din_d = s_q ^ cph_dout;
      default: din_d = din_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    din_q <= '0;
    else if (fire) din_q <= din_d;
  end

  assign cph_start = start_q;
  assign cph_din   = din_q;

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R9
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |-> $stable(din_q));
endmodule

// File: rtl/rng_recur_ctrl.sv
module rng_recur_ctrl
  import rngc_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_wr,
  input  logic [DW-1:0] seed_in,
  input  logic [DW-1:0] tstamp,
  input  logic          req,
  output logic          rnd_valid,
  output logic [DW-1:0] rnd_out,
  output logic          cph_start,
  output logic [DW-1:0] cph_din,
  input  logic          cph_done,
  input  logic [DW-1:0] cph_dout
);
  phase_e        phase;
  logic          fire, ld_s, ld_r, ld_v;
  logic [DW-1:0] s_q, r_q, v_q;

  rngc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cph_done  (cph_done),
    .phase     (phase),
    .fire      (fire),
    .ld_s      (ld_s),
    .ld_r      (ld_r),
    .ld_v      (ld_v),
    .rnd_valid (rnd_valid)
  );

  rngc_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .ld_s     (ld_s),
    .ld_r     (ld_r),
    .ld_v     (ld_v),
    .seed_wr  (seed_wr),
    .seed_in  (seed_in),
    .cph_dout (cph_dout),
    .s_q      (s_q),
    .r_q      (r_q),
    .v_q      (v_q)
  );

  rngc_port #(.DW(DW)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .fire      (fire),
    .tstamp    (tstamp),
    .cph_dout  (cph_dout),
    .s_q       (s_q),
    .v_q       (v_q),
    .cph_start (cph_start),
    .cph_din   (cph_din)
  );

  assign rnd_out = r_q;

  // R5
  valid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |-> $past(cph_done));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cph_start |=> !cph_start);
endmodule

// File: tb/rng_recur_ctrl_test.sv
module rng_recur_ctrl_test;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          seed_wr, req;
  logic [DW-1:0] seed_in, tstamp;
  logic          rnd_valid, cph_start;
  logic [DW-1:0] rnd_out, cph_din;
  logic          cph_done;
  logic [DW-1:0] cph_dout;

  int nvec = 0, nerr = 0;
  int n_start = 0, n_out = 0;
  int lat = 48;
  int cnt = 0;
  logic [DW-1:0] pend;
  logic          prev_vld = 1'b0;
  logic          finished = 1'b0;
  logic [DW-1:0] mv = '0;
  logic [DW-1:0] last_rnd = '0;
  string         ctx = "";
  logic [DW-1:0] q_din[$];
  logic [DW-1:0] q_rnd[$];

  always #10 clk = ~clk;  // 50 MHz

  rng_recur_ctrl #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .seed_wr(seed_wr), .seed_in(seed_in),
    .tstamp(tstamp), .req(req), .rnd_valid(rnd_valid), .rnd_out(rnd_out),
    .cph_start(cph_start), .cph_din(cph_din), .cph_done(cph_done),
    .cph_dout(cph_dout)
  );

  // Reversible stub cipher: rotate left by 7 and XOR a fixed key word.
  function automatic logic [DW-1:0] ciph(input logic [DW-1:0] x);
    return {x[DW-8:0], x[DW-1:DW-7]} ^ 64'h3C5A_96E1_0F2D_7B48;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; cph_done <= 1'b0; cph_dout <= '0; pend <= '0;
    end else if (cph_start) begin
      cnt <= lat; pend <= ciph(cph_din); cph_done <= 1'b0;
    end else if (cnt == 1) begin
      cph_done <= 1'b1; cph_dout <= pend; cnt <= 0;
    end else begin
      cph_done <= 1'b0;
      if (cnt > 1) cnt <= cnt - 1;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares every cipher launch and every output against the queues.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (cph_start) begin
        string tg;
        case (n_start % 3)
          0: tg = "R2 call1 din";
          1: tg = "R3 call2 din";
          default: tg = "R4 call3 din";
        endcase
        n_start++;
        if (q_din.size() == 0) check({tg, " unexpected start R11 ", ctx}, 64'd1, 64'd0);
        else check({tg, " ", ctx}, cph_din, q_din.pop_front());
      end
      if (rnd_valid) begin
        n_out++;
        if (prev_vld) check("R5 valid width", 64'd1, 64'd0);
        if (q_rnd.size() == 0) check("R5 unexpected valid", 64'd1, 64'd0);
        else begin
          last_rnd = q_rnd[0];
          check({"R5 R6 rnd_out ", ctx}, rnd_out, q_rnd.pop_front());
        end
      end
      prev_vld <= rnd_valid;
    end
  end

  task automatic load_seed(input logic [DW-1:0] v);
    @(negedge clk); seed_wr = 1'b1; seed_in = v;
    @(negedge clk); seed_wr = 1'b0;
    mv = v;
  endtask

  // Driver: pushes expectations, issues a request, optional mid-run disturbance.
  task automatic gen(input logic [DW-1:0] t, input bit disturb, input string c);
    logic [DW-1:0] s, r;
    int target;
    ctx = c;
    s = ciph(t);
    r = ciph(s ^ mv);
    q_din.push_back(t);
    q_din.push_back(s ^ mv);
    q_din.push_back(s ^ r);
    q_rnd.push_back(r);
    mv = ciph(s ^ r);
    target = n_out + 1;
    @(negedge clk); tstamp = t; req = 1'b1;
    @(negedge clk); req = 1'b0; tstamp = ~t;
    if (disturb) begin
      repeat (3) @(negedge clk);
      seed_wr = 1'b1; seed_in = 64'hDEAD_BEEF_0BAD_F00D; req = 1'b1;
      @(negedge clk); seed_wr = 1'b0; req = 1'b0;
    end
    while (n_out < target) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; seed_wr = 1'b0; req = 1'b0; seed_in = '0; tstamp = '0;
    repeat (3) @(negedge clk);
    check("R1 rnd_valid", {63'd0, rnd_valid}, 64'd0);
    check("R1 cph_start", {63'd0, cph_start}, 64'd0);
    check("R1 rnd_out", rnd_out, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    gen(64'h0000_0000_0000_0001, 1'b0, "R1 zero seed");
    gen(64'h1234_5678_9ABC_DEF0, 1'b0, "R6 chained seed");
    load_seed(64'hA5A5_0000_FFFF_5A5A);
    lat = 1;
    gen(64'h0F0F_F0F0_0F0F_F0F0, 1'b0, "R7 loaded seed");
    lat = 5;
    gen(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R8 R11 busy seed and req");
    gen(64'h8000_0000_0000_0000, 1'b0, "R8 seed still intact");
    repeat (30) @(negedge clk);
    check("R10 rnd_out held while idle", rnd_out, last_rnd);
    lat = 48;
    gen(64'h0123_4567_89AB_CDEF, 1'b0, "R6 after hold");
    repeat (100) @(negedge clk);
    check("R11 total cipher calls", 64'(n_start), 64'd18);
    check("R11 outputs", 64'(n_out), 64'd6);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule